// File: doc/BRIEF.md
# Peripheral Interrupt Routing Matrix

This block steers a parameterised set of peripheral interrupt sources onto 31 numbered CPU interrupt lines and presents one request to the processor core. Every source has a map register that names the CPU line it drives. Line number 0 means the source is detached. Each line then has its own enable bit, trigger-type bit, clear bit and 4-bit priority. A global threshold decides which priorities may reach the core at all.

Sources that share a line are ORed together. A line set to edge mode captures a rising edge of that OR in a latch, which stays set until software clears it. A line in level mode follows the OR directly. A line is eligible when it is pending, enabled, has a non-zero priority and meets the threshold. Among the eligible lines, the one with the highest priority wins, and a tie goes to the lowest line number. The request and the winning line number are registered outputs.

Software reaches all configuration through a simple word-addressed write/read bus. The map registers sit at `4*i` for source `i`. Enable is at 0x100, type at 0x104, threshold at 0x108, clear at 0x10C and the raw pending status at 0x110. The priority register for line `L` is at `0x200 + 4*L`. In the enable, type, clear and status registers, bit `L` belongs to line `L`, and bit 0 always reads 0.

Top module: `irq_route_matrix`

## Requirements
- R1: The map register of source `i` is at byte address `4*i`. Its low 5 bits hold the CPU line number, and all other bits read back as 0.
- R2: A map value of 0 detaches the source, so it drives no line. When no line is eligible, `irq_line` is 0.
- R3: Sources mapped to the same line are ORed, and any one of them makes that line pending.
- R4: A line whose enable bit (bit L of 0x100) is 0 never raises `irq_req`, even while it is pending.
- R5: Type bit L (0x104) set to 1 makes line L edge-triggered: a rising edge of its ORed input sets a latch, which stays set after the input falls. Type bit 0 makes the line level-sensitive, so it follows the ORed input.
- R6: While clear bit L (0x10C) is 1, the edge latch of line L is held cleared, the line is not pending, and rising edges are ignored. Writing the bit back to 0 does not set the latch.
- R7: The priority register of line L is at `0x200 + 4*L`, 4 bits wide and readable. A priority of 0 keeps the line from ever winning.
- R8: The threshold register (0x108) resets to 1. A line may interrupt only if its priority is greater than or equal to the threshold.
- R9: Among eligible lines, the highest priority wins, and equal priorities go to the lowest line number. The winner's number is driven on `irq_line`.
- R10: The status register (0x110) reads the raw pending bit of every line, before enable, priority and threshold gating.
- R11: Reset clears all map, enable, type, clear and priority registers, and drives `irq_req` and `irq_line` to 0.
- R12: Register writes take effect on the next clock edge. `irq_req` and `irq_line` are registered, so a newly pending line shows up one clock after its source asserts and not in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_irq | input | NUM_SRC | Peripheral interrupt sources, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| irq_req | output | 1 | Registered interrupt request to the core |
| irq_line | output | 5 | Registered number of the winning line, 0 when idle |

## Verification
The bench builds the block with NUM_SRC=4 and leaves the other parameters at their defaults, so all 31 lines and the full 4-bit priority range are in play. Four sources are enough to put two of them on one line, which exercises the OR sharing. They also allow one source on line 31, which covers the top line boundary. The remaining source drives a level line that competes with an edge-latched line for priority and tie-break. Threshold changes and priority 0 are then applied to that same pair of lines.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
   localparam int unsigned MAP_BASE   = 32'h000;
   localparam int unsigned EN_ADDR    = 32'h100;
   localparam int unsigned TYPE_ADDR  = 32'h104;
   localparam int unsigned THR_ADDR   = 32'h108;
   localparam int unsigned CLR_ADDR   = 32'h10C;
   localparam int unsigned STAT_ADDR  = 32'h110;
   localparam int unsigned PRIO_BASE  = 32'h200;
   localparam int unsigned MAX_LINES  = 31;
   localparam int unsigned MAX_SRC    = 64;
endpackage

// File: rtl/irqm_regs.sv
module irqm_regs
   import irqm_pkg::*;
#(
   parameter int NUM_SRC    = 16,
   parameter int NUM_LINES  = 31,
   parameter int LINE_W     = 5,
   parameter int PRIO_W     = 4,
   parameter int ADDR_W     = 10,
   parameter int THRESH_RST = 1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                bus_we,
   input  logic [ADDR_W-1:0]                   bus_addr,
   input  logic [31:0]                         bus_wdata,
   output logic [31:0]                         bus_rdata,
   input  logic [NUM_LINES:1]                  pend_i,
   output logic [NUM_SRC-1:0][LINE_W-1:0]      map_o,
   output logic [NUM_LINES:1]                  en_o,
   output logic [NUM_LINES:1]                  type_o,
   output logic [NUM_LINES:1]                  clr_o,
   output logic [NUM_LINES:1][PRIO_W-1:0]      prio_o,
   output logic [PRIO_W-1:0]                   thresh_o
);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_ADDR);
   localparam logic [ADDR_W-1:0] A_TYPE = ADDR_W'(TYPE_ADDR);
   localparam logic [ADDR_W-1:0] A_THR  = ADDR_W'(THR_ADDR);
   localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_ADDR);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

   // per-source map registers
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_map
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            map_o[i] <= '0;
         else if (bus_we && bus_addr == ADDR_W'(MAP_BASE + 4*i))
            map_o[i] <= bus_wdata[LINE_W-1:0];
      end
   end

   // per-line priority registers
   for (genvar l = 1; l <= NUM_LINES; l++) begin : g_prio
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            prio_o[l] <= '0;
         else if (bus_we && bus_addr == ADDR_W'(PRIO_BASE + 4*l))
            prio_o[l] <= bus_wdata[PRIO_W-1:0];
      end
   end

   // line-wide vector registers and threshold
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o     <= '0;
         type_o   <= '0;
         clr_o    <= '0;
         thresh_o <= PRIO_W'(THRESH_RST);
      end else if (bus_we) begin
         if (bus_addr == A_EN)   en_o     <= bus_wdata[NUM_LINES:1];
         if (bus_addr == A_TYPE) type_o   <= bus_wdata[NUM_LINES:1];
         if (bus_addr == A_CLR)  clr_o    <= bus_wdata[NUM_LINES:1];
         if (bus_addr == A_THR)  thresh_o <= bus_wdata[PRIO_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_EN)   bus_rdata = 32'({en_o, 1'b0});
      if (bus_addr == A_TYPE) bus_rdata = 32'({type_o, 1'b0});
      if (bus_addr == A_CLR)  bus_rdata = 32'({clr_o, 1'b0});
      if (bus_addr == A_STAT) bus_rdata = 32'({pend_i, 1'b0});
      if (bus_addr == A_THR)  bus_rdata = 32'(thresh_o);
      for (int i = 0; i < NUM_SRC; i++)
         if (bus_addr == ADDR_W'(MAP_BASE + 4*i)) bus_rdata = 32'(map_o[i]);
      for (int l = 1; l <= NUM_LINES; l++)
         if (bus_addr == ADDR_W'(PRIO_BASE + 4*l)) bus_rdata = 32'(prio_o[l]);
   end

   // thresholds take the written value on the next edge
   p_thr_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_THR) |=> thresh_o == $past(bus_wdata[PRIO_W-1:0]));
endmodule

// File: rtl/irqm_lines.sv
module irqm_lines #(
   parameter int NUM_SRC   = 16,
   parameter int NUM_LINES = 31,
   parameter int LINE_W    = 5
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_SRC-1:0]             src_i,
   input  logic [NUM_SRC-1:0][LINE_W-1:0] map_i,
   input  logic [NUM_LINES:1]             type_i,
   input  logic [NUM_LINES:1]             clr_i,
   output logic [NUM_LINES:1]             pend_o
);
   logic [NUM_LINES:1] comb_now;
   logic [NUM_LINES:1] prev_q;
   logic [NUM_LINES:1] latch_q;
   logic [NUM_LINES:1] rise;

   for (genvar l = 1; l <= NUM_LINES; l++) begin : g_line
      logic [NUM_SRC-1:0] hit;
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
         assign hit[i] = (map_i[i] == LINE_W'(l));
      end
      assign comb_now[l] = |(src_i & hit);
      assign rise[l]     = comb_now[l] & ~prev_q[l];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q[l]  <= 1'b0;
            latch_q[l] <= 1'b0;
         end else begin
            prev_q[l]  <= comb_now[l];
            latch_q[l] <= clr_i[l] ? 1'b0 : (latch_q[l] | rise[l]);
         end
      end

      assign pend_o[l] = type_i[l] ? ((latch_q[l] | rise[l]) & ~clr_i[l])
                                   : comb_now[l];

      p_clr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
         clr_i[l] |=> !latch_q[l]);
      p_latch_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (latch_q[l] && !clr_i[l]) |=> latch_q[l]);
   end
endmodule

// File: rtl/irqm_arb.sv
module irqm_arb #(
   parameter int NUM_LINES = 31,
   parameter int LINE_W    = 5,
   parameter int PRIO_W    = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_LINES:1]             pend_i,
   input  logic [NUM_LINES:1]             en_i,
   input  logic [NUM_LINES:1][PRIO_W-1:0] prio_i,
   input  logic [PRIO_W-1:0]              thresh_i,
   output logic                           req_o,
   output logic [LINE_W-1:0]              line_o
);
   logic [NUM_LINES:1] elig;
   logic               found;
   logic [PRIO_W-1:0]  best_prio;
   logic [LINE_W-1:0]  best_line;
   logic [PRIO_W-1:0]  win_prio_q;

   for (genvar l = 1; l <= NUM_LINES; l++) begin : g_elig
      assign elig[l] = pend_i[l] & en_i[l] & (prio_i[l] != '0)
                       & (prio_i[l] >= thresh_i);
   end

   // strict compare while scanning upward keeps the lowest line on ties
   always_comb begin
      found     = 1'b0;
      best_prio = '0;
      best_line = '0;
      for (int l = 1; l <= NUM_LINES; l++) begin
         if (elig[l] && (!found || prio_i[l] > best_prio)) begin
            found     = 1'b1;
            best_prio = prio_i[l];
            best_line = LINE_W'(l);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_o      <= 1'b0;
         line_o     <= '0;
         win_prio_q <= '0;
      end else begin
         req_o      <= found;
         line_o     <= best_line;
         win_prio_q <= best_prio;
      end
   end

   p_req_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (|elig) |=> req_o);
   p_idle_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(|elig) |=> (!req_o && line_o == '0));
   p_line_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> line_o != '0);
   p_thresh_met_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> (win_prio_q >= $past(thresh_i) && win_prio_q != '0));
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
   import irqm_pkg::*;
#(
   parameter int NUM_SRC    = 16,
   parameter int NUM_LINES  = 31,
   parameter int PRIO_W     = 4,
   parameter int ADDR_W     = 10,
   parameter int THRESH_RST = 1,
   localparam int LINE_W    = $clog2(NUM_LINES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  src_irq,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic                irq_req,
   output logic [LINE_W-1:0]   irq_line
);
   // elaboration-time parameter checks
   if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_lines
      $error("NUM_LINES out of range");
   end
   if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_src
      $error("NUM_SRC out of range");
   end
   if (PRIO_W < 1 || PRIO_W > 8 || THRESH_RST >= (1 << PRIO_W)) begin : g_bad_prio
      $error("PRIO_W or THRESH_RST out of range");
   end
   if ((1 << ADDR_W) <= (PRIO_BASE + 4*NUM_LINES)) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic [NUM_SRC-1:0][LINE_W-1:0] map_w;
   logic [NUM_LINES:1]             en_w, type_w, clr_w, pend_w;
   logic [NUM_LINES:1][PRIO_W-1:0] prio_w;
   logic [PRIO_W-1:0]              thresh_w;

   irqm_regs #(
      .NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES), .LINE_W(LINE_W),
      .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .THRESH_RST(THRESH_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend_i(pend_w),
      .map_o(map_w), .en_o(en_w), .type_o(type_w), .clr_o(clr_w),
      .prio_o(prio_w), .thresh_o(thresh_w)
   );

   irqm_lines #(
      .NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES), .LINE_W(LINE_W)
   ) u_lines (
      .clk(clk), .rst_n(rst_n), .src_i(src_irq), .map_i(map_w),
      .type_i(type_w), .clr_i(clr_w), .pend_o(pend_w)
   );

   irqm_arb #(
      .NUM_LINES(NUM_LINES), .LINE_W(LINE_W), .PRIO_W(PRIO_W)
   ) u_arb (
      .clk(clk), .rst_n(rst_n), .pend_i(pend_w), .en_i(en_w),
      .prio_i(prio_w), .thresh_i(thresh_w), .req_o(irq_req), .line_o(irq_line)
   );
endmodule

// File: tb/sim_irq_route_matrix.sv
module sim_irq_route_matrix;
   localparam int CLK_PERIOD = 10;
   localparam int NSRC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NSRC-1:0] src_irq = '0;
   logic        bus_we = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_req;
   logic [4:0]  irq_line;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic       req;
      logic [4:0] line;
      string      tag;
   } exp_t;
   exp_t sb[$];

   irq_route_matrix #(.NUM_SRC(NSRC)) u0 (
      .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_req(irq_req), .irq_line(irq_line)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // monitor: pops one expected item per falling edge
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         n_cmp++;
         if (irq_req !== e.req || irq_line !== e.line) begin
            n_bad++;
            $display("FAIL %s: req/line = %0b/%0d, expected %0b/%0d",
                     e.tag, irq_req, irq_line, e.req, e.line);
         end
      end
   end

   // driver: advance one edge, then queue the expected registered output
   task automatic chk(input logic r, input logic [4:0] l, input string tag);
      exp_t e;
      @(posedge clk); #1;
      e.req = r; e.line = l; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_we = 1'b1; bus_addr = 10'(a); bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic rd(input int a, input logic [31:0] exp, input string tag);
      @(posedge clk); #1;
      bus_addr = 10'(a);
      #1;
      n_cmp++;
      if (bus_rdata !== exp) begin
         n_bad++;
         $display("FAIL %s: read 0x%0h = 0x%0h, expected 0x%0h", tag, a, bus_rdata, exp);
      end
   endtask

   function automatic int pa(input int l);
      return 32'h200 + 4*l;
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] en;
      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      chk(1'b0, 5'd0, "R11 reset outputs");
      rd(32'h000, 32'h0, "R11 map after reset");
      rd(32'h100, 32'h0, "R11 enable after reset");
      rd(pa(5), 32'h0, "R11 prio after reset");
      rd(32'h108, 32'h1, "R8 threshold reset value");
      rst_n = 1'b1;

      // R1 map register position and field width
      wr(32'h000, 32'hFFFF_FFE5);
      rd(32'h000, 32'h5, "R1 map low 5 bits");

      // R5 level line with R12 timing
      wr(pa(5), 32'h3);
      en = 32'h1 << 5;
      wr(32'h100, en);
      src_irq[0] = 1'b1;
      #1;
      n_cmp++;
      if (irq_req !== 1'b0) begin
         n_bad++;
         $display("FAIL R12: req in same cycle = %0b, expected 0", irq_req);
      end
      chk(1'b1, 5'd5, "R12 request one cycle after source");
      chk(1'b1, 5'd5, "R5 level line held");
      src_irq[0] = 1'b0;
      chk(1'b0, 5'd0, "R5 level line follows source low");

      // R4 disabled line, R10 raw status
      src_irq[0] = 1'b1;
      wr(32'h100, 32'h0);
      chk(1'b0, 5'd0, "R4 disabled line silent");
      rd(32'h110, 32'h1 << 5, "R10 raw pending before gating");

      // R2 detached source
      wr(32'h000, 32'h0);
      chk(1'b0, 5'd0, "R2 detached output");
      rd(32'h110, 32'h0, "R2 detached source drives no line");

      // R3 two sources ORed on line 7
      src_irq[0] = 1'b0;
      wr(32'h004, 32'd7);
      wr(32'h008, 32'd7);
      wr(pa(7), 32'h4);
      en = 32'h1 << 7;
      wr(32'h100, en);
      src_irq[1] = 1'b1;
      chk(1'b1, 5'd7, "R3 first source");
      src_irq[1] = 1'b0; src_irq[2] = 1'b1;
      chk(1'b1, 5'd7, "R3 second source");
      src_irq[2] = 1'b0;
      chk(1'b0, 5'd0, "R3 none active");

      // R5 edge latch and R6 clear
      wr(32'h104, 32'h1 << 7);
      src_irq[1] = 1'b1;
      chk(1'b1, 5'd7, "R5 edge sets latch");
      src_irq[1] = 1'b0;
      chk(1'b1, 5'd7, "R5 latch holds after source falls");
      wr(32'h10C, 32'h1 << 7);
      chk(1'b0, 5'd0, "R6 clear empties latch");
      src_irq[1] = 1'b1;
      chk(1'b0, 5'd0, "R6 edge ignored while clear high");
      rd(32'h110, 32'h0, "R6 status while clear high");
      src_irq[1] = 1'b0;
      wr(32'h10C, 32'h0);
      chk(1'b0, 5'd0, "R6 releasing clear sets nothing");
      src_irq[1] = 1'b1;
      chk(1'b1, 5'd7, "R5 new edge latches again");
      src_irq[1] = 1'b0;

      // R9 arbitration between level line 5 and latched line 7
      wr(32'h000, 32'd5);
      en = (32'h1 << 5) | (32'h1 << 7);
      wr(32'h100, en);
      src_irq[0] = 1'b1;
      chk(1'b1, 5'd7, "R9 higher priority wins");
      wr(pa(5), 32'h4);
      chk(1'b1, 5'd5, "R9 tie goes to lower line");
      wr(pa(5), 32'h6);
      chk(1'b1, 5'd5, "R9 line 5 now higher");

      // R8 threshold
      wr(32'h108, 32'h5);
      chk(1'b1, 5'd5, "R8 priority above threshold");
      wr(pa(5), 32'h4);
      chk(1'b0, 5'd0, "R8 both below threshold");
      wr(32'h108, 32'h4);
      chk(1'b1, 5'd5, "R8 equal to threshold allowed");
      rd(32'h108, 32'h4, "R8 threshold readback");

      // R7 priority zero disables
      wr(32'h108, 32'h0);
      wr(pa(5), 32'h0);
      chk(1'b1, 5'd7, "R7 priority 0 never wins");
      rd(pa(7), 32'h4, "R7 priority register readback");

      // R9 top line boundary, R10 status with several bits
      wr(32'h00C, 32'd31);
      wr(pa(31), 32'hF);
      en = en | (32'h1 << 31);
      wr(32'h100, en);
      src_irq[3] = 1'b1;
      chk(1'b1, 5'd31, "R9 line 31 with priority 15");
      rd(32'h110, (32'h1 << 5) | (32'h1 << 7) | (32'h1 << 31), "R10 multi-line status");

      // R11 reset in mid-run
      rst_n = 1'b0;
      chk(1'b0, 5'd0, "R11 outputs under reset");
      rd(32'h00C, 32'h0, "R11 map cleared");
      rd(32'h104, 32'h0, "R11 type cleared");
      rd(pa(31), 32'h0, "R11 priority cleared");
      rd(32'h108, 32'h1, "R11 threshold back to 1");
      rst_n = 1'b1;
      chk(1'b0, 5'd0, "R11 no request after reset release");

      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule